// File: doc/BRIEF.md
# Sign-Split Reordered Accumulator

This block sums a stream of signed two's-complement operands and splits the stream into blocks, where an input flag marks the last operand of each block. Operands that are zero or positive go into one running total. Negative operands go into a second running total, which holds the sum of their magnitudes. Within a block, each running total only ever receives values of one sign. The one step that combines opposite signs is a single subtraction when the block closes. That subtraction is also the one place where long, timing-critical carry chains can appear. Small numbers of opposite sign, with one plus minus one as the worst case, give the longest carry ripples.

Each operand is also sorted by magnitude. A small operand is added on a narrow adder slice over the low bits of its running total, and its carry-out increments the upper bits. A large operand uses the full-width adder. The running totals are wide enough that a block of up to the maximum length cannot overflow. The result of each block is exact, and it appears on a registered output one cycle after the last operand is accepted. Both running totals then clear for the next block.

Top module: `sign_split_acc`

## Requirements
- R1: After reset, `out_valid` is 0 and both running totals are zero. The first block after reset therefore sums from zero.
- R2: An operand whose sign bit (bit `W_DATA-1`) is 0, including zero, adds only to the non-negative total. An operand whose sign bit is 1 adds its magnitude only to the negative total.
- R3: An operand whose magnitude is below 2^(`W_NARROW`-1) is added on the narrow path, where the carry-out of the low `W_NARROW` bits increments the upper part. Any other operand is added on the full-width path. Both paths give the exact sum, including at the magnitude boundary and across carries out of the low bits.
- R4: When `in_valid` and `in_last` are both 1 at a clock edge, `out_valid` is 1 for the following cycle. Otherwise `out_valid` is 0 for the following cycle.
- R5: `out_result` is a signed `W_ACC`-bit value equal to the exact sum of all operands accepted in the block, including the last one.
- R6: Accepting an operand with `in_last` = 1 clears both running totals, so each block's result is independent of earlier blocks.
- R7: While `in_valid` is 0, `in_data` and `in_last` have no effect on the running totals or on `out_valid`.
- R8: A block of one operand, with `in_last` set on its first operand, returns that operand sign-extended to `W_ACC` bits.
- R9: The most negative operand, -2^(`W_DATA`-1), is accumulated with its full magnitude 2^(`W_DATA`-1).
- R10: `W_ACC` = `W_DATA` + clog2(`MAX_LEN`). A block of `MAX_LEN` operands that are all the most negative value, or all the most positive value, gives the exact result without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand is presented this cycle |
| in_data | input | W_DATA | Signed two's-complement operand |
| in_last | input | 1 | Operand closes the current block |
| out_valid | output | 1 | Block result is valid this cycle |
| out_result | output | W_ACC | Signed sum of the closed block |

## Verification
The bench builds the block with `W_DATA` = 6, `W_NARROW` = 3 and `MAX_LEN` = 8, which gives a 9-bit result. With operands this narrow, every ordered pair of operands can be run as its own two-operand block, and every single value can be run as a one-operand block. Together these sweeps cover every sign combination, both sides of the narrow-path boundary at magnitude 4, and the most negative operand. Full-length blocks of extreme values reach both ends of the 9-bit result range. Long runs of small operands force repeated carries out of the narrow slice. Idle cycles carry junk data with the last flag set, to confirm that inputs are ignored while `in_valid` is low.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
   typedef enum logic {
      PATH_FULL   = 1'b0,
      PATH_NARROW = 1'b1
   } path_e;
endpackage

// File: rtl/ssa_route.sv
module ssa_route
   import ssa_pkg::*;
#(
   parameter int W_DATA   = 8,
   parameter int W_NARROW = 4
) (
   input  logic [W_DATA-1:0] op,
   output logic              is_neg,
   output logic [W_DATA-1:0] mag,
   output path_e             path
);
   localparam int SMALL_MSB = W_NARROW - 1;

   always_comb begin
      is_neg = op[W_DATA-1];
      mag    = is_neg ? (~op + 1'b1) : op;
      path   = (mag[W_DATA-1:SMALL_MSB] == '0) ? PATH_NARROW : PATH_FULL;
   end
endmodule

// File: rtl/ssa_mag_acc.sv
module ssa_mag_acc
   import ssa_pkg::*;
#(
   parameter int W_DATA    = 8,
   parameter int W_NARROW  = 4,
   parameter int W_ACC     = 12,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              add_en,
   input  logic              clear,
   input  path_e             path,
   input  logic [W_DATA-1:0] mag,
   output logic [W_ACC-1:0]  acc_q,
   output logic [W_ACC-1:0]  acc_nxt
);
   localparam int W_UP = W_ACC - W_NARROW;

   logic [W_ACC-1:0] full_sum;
   logic [W_ACC-1:0] sum;

   assign full_sum = acc_q + {{(W_ACC-W_DATA){1'b0}}, mag};

   generate
      if (NARROW_EN) begin : g_split
         logic [W_NARROW:0] lo_sum;
         logic [W_UP-1:0]   up_sum;
         always_comb begin
            lo_sum = {1'b0, acc_q[W_NARROW-1:0]} + {1'b0, mag[W_NARROW-1:0]};
            up_sum = acc_q[W_ACC-1:W_NARROW] + {{(W_UP-1){1'b0}}, lo_sum[W_NARROW]};
            sum    = (path == PATH_NARROW) ? {up_sum, lo_sum[W_NARROW-1:0]} : full_sum;
         end
      end else begin : g_full
         logic unused_path;
         assign unused_path = path;
         assign sum = full_sum;
      end
   endgenerate

   assign acc_nxt = add_en ? sum : acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) acc_q <= '0;
      else                 acc_q <= acc_nxt;
   end
endmodule

// File: rtl/ssa_combine.sv
module ssa_combine #(
   parameter int W_ACC = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic [W_ACC-1:0] pos_tot,
   input  logic [W_ACC-1:0] neg_tot,
   output logic             res_valid,
   output logic [W_ACC-1:0] res
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res       <= '0;
      end else begin
         res_valid <= fire;
         if (fire) res <= pos_tot - neg_tot;
      end
   end
endmodule

// File: rtl/sign_split_acc.sv
module sign_split_acc
   import ssa_pkg::*;
#(
   parameter int W_DATA    = 8,
   parameter int W_NARROW  = 4,
   parameter int MAX_LEN   = 16,
   parameter bit NARROW_EN = 1'b1,
   localparam int W_ACC    = W_DATA + $clog2(MAX_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [W_DATA-1:0] in_data,
   input  logic              in_last,
   output logic              out_valid,
   output logic [W_ACC-1:0]  out_result
);
   generate
      if (W_NARROW < 2 || W_NARROW > W_DATA) begin : g_bad_narrow
         $error("sign_split_acc: W_NARROW must lie in 2..W_DATA");
      end
      if (MAX_LEN < 2) begin : g_bad_len
         $error("sign_split_acc: MAX_LEN must be at least 2");
      end
   endgenerate

   logic              is_neg;
   logic [W_DATA-1:0] mag;
   path_e             path;
   logic              narrow_sel;
   logic              blk_end;
   logic [W_ACC-1:0]  pos_sum, neg_sum;
   logic [W_ACC-1:0]  pos_nxt, neg_nxt;

   ssa_route #(.W_DATA(W_DATA), .W_NARROW(W_NARROW)) u_route (
      .op(in_data), .is_neg(is_neg), .mag(mag), .path(path)
   );

   assign narrow_sel = (path == PATH_NARROW);
   assign blk_end    = in_valid & in_last;

   ssa_mag_acc #(.W_DATA(W_DATA), .W_NARROW(W_NARROW), .W_ACC(W_ACC),
                 .NARROW_EN(NARROW_EN)) u_pos (
      .clk(clk), .rst_n(rst_n), .add_en(in_valid & ~is_neg), .clear(blk_end),
      .path(path), .mag(mag), .acc_q(pos_sum), .acc_nxt(pos_nxt)
   );

   ssa_mag_acc #(.W_DATA(W_DATA), .W_NARROW(W_NARROW), .W_ACC(W_ACC),
                 .NARROW_EN(NARROW_EN)) u_neg (
      .clk(clk), .rst_n(rst_n), .add_en(in_valid & is_neg), .clear(blk_end),
      .path(path), .mag(mag), .acc_q(neg_sum), .acc_nxt(neg_nxt)
   );

   ssa_combine #(.W_ACC(W_ACC)) u_comb (
      .clk(clk), .rst_n(rst_n), .fire(blk_end), .pos_tot(pos_nxt),
      .neg_tot(neg_nxt), .res_valid(out_valid), .res(out_result)
   );
endmodule

// File: rtl/ssa_checker.sv
module ssa_checker #(
   parameter int W_DATA   = 8,
   parameter int W_NARROW = 4,
   parameter int W_ACC    = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_last,
   input logic              out_valid,
   input logic              is_neg,
   input logic              narrow_sel,
   input logic [W_ACC-1:0]  pos_sum,
   input logic [W_ACC-1:0]  neg_sum
);
   localparam int W_UP = W_ACC - W_NARROW;

   logic [W_UP-1:0] pos_up, neg_up;
   assign pos_up = pos_sum[W_ACC-1:W_NARROW];
   assign neg_up = neg_sum[W_ACC-1:W_NARROW];

   assert_pulse_on_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |=> out_valid);

   assert_quiet_otherwise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_last) |=> !out_valid);

   assert_clear_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |=> (pos_sum == '0 && neg_sum == '0));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(pos_sum) && $stable(neg_sum)));

   assert_nonneg_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_last && !is_neg) |=> $stable(neg_sum));

   assert_neg_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_last && is_neg) |=> $stable(pos_sum));

   assert_narrow_step_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_last && !is_neg && narrow_sel)
         |=> ((pos_up - $past(pos_up)) <= W_UP'(1)));

   assert_narrow_step_neg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_last && is_neg && narrow_sel)
         |=> ((neg_up - $past(neg_up)) <= W_UP'(1)));
endmodule

bind sign_split_acc ssa_checker #(
   .W_DATA(W_DATA), .W_NARROW(W_NARROW), .W_ACC(W_ACC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
   .out_valid(out_valid), .is_neg(is_neg), .narrow_sel(narrow_sel),
   .pos_sum(pos_sum), .neg_sum(neg_sum)
);

// File: tb/sim_sign_split_acc.sv
module sim_sign_split_acc;
   localparam int CLK_PERIOD = 10;
   localparam int W_DATA     = 6;
   localparam int W_NARROW   = 3;
   localparam int MAX_LEN    = 8;
   localparam int W_ACC      = W_DATA + $clog2(MAX_LEN);
   localparam int VMIN       = -(1 << (W_DATA-1));
   localparam int VMAX       = (1 << (W_DATA-1)) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [W_DATA-1:0] in_data = '0;
   logic              in_last = 1'b0;
   logic              out_valid;
   logic [W_ACC-1:0]  out_result;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sign_split_acc #(.W_DATA(W_DATA), .W_NARROW(W_NARROW), .MAX_LEN(MAX_LEN)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .out_valid(out_valid), .out_result(out_result)
   );

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
         report();
      end
   end

   task automatic push(input int v, input bit last);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = v[W_DATA-1:0];
      in_last  = last;
   endtask

   task automatic idle(input int junk);
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = junk[W_DATA-1:0];
      in_last  = 1'b1;
   endtask

   task automatic check_bit(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   // Called right after the last operand was pushed: the next negedge follows
   // the accepting edge, so the registered result is visible there.
   task automatic close_check(input string tag, input int exp);
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      checks++;
      if (out_valid !== 1'b1 || $signed(out_result) != exp) begin
         fails++;
         $display("FAIL %s: actual valid=%0b result=%0d expected valid=1 result=%0d",
                  tag, out_valid, $signed(out_result), exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_bit("R1 out_valid in reset", out_valid, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_bit("R1 out_valid after reset", out_valid, 1'b0);

      // R1: first block sums from zero
      push(5, 1'b0); push(-2, 1'b1);
      close_check("R1 first block", 3);

      // R8, R9: every single-operand block, including the most negative value
      for (int v = VMIN; v <= VMAX; v++) begin
         push(v, 1'b1);
         close_check((v == VMIN) ? "R9 most negative alone" : "R8 single operand", v);
      end

      // R2, R3, R5: every ordered pair, crossing sign and the narrow boundary
      for (int a = VMIN; a <= VMAX; a++) begin
         for (int b = VMIN; b <= VMAX; b++) begin
            push(a, 1'b0); push(b, 1'b1);
            close_check("R5 pair sum", a + b);
         end
      end

      // R3: repeated narrow carries out of the low slice
      for (int k = 0; k < MAX_LEN; k++) push(3, k == MAX_LEN-1);
      close_check("R3 narrow carry positive", 3 * MAX_LEN);
      for (int k = 0; k < MAX_LEN; k++) push(-3, k == MAX_LEN-1);
      close_check("R3 narrow carry negative", -3 * MAX_LEN);
      for (int k = 0; k < MAX_LEN; k++) push((k % 2) ? 4 : 3, k == MAX_LEN-1);
      close_check("R3 boundary mix", 28);

      // R2, R5: alternating one and minus one, zeros on the non-negative side
      for (int k = 0; k < MAX_LEN; k++) push((k % 2) ? -1 : 1, k == MAX_LEN-1);
      close_check("R2 plus minus one", 0);
      push(0, 1'b0); push(0, 1'b0); push(-7, 1'b1);
      close_check("R2 zeros with negative", -7);

      // R10: full-length extremes
      for (int k = 0; k < MAX_LEN; k++) push(VMIN, k == MAX_LEN-1);
      close_check("R10 all most negative", VMIN * MAX_LEN);
      for (int k = 0; k < MAX_LEN; k++) push(VMAX, k == MAX_LEN-1);
      close_check("R10 all most positive", VMAX * MAX_LEN);

      // R7: idle cycles with junk data and last set change nothing
      push(9, 1'b0);
      idle(-20);
      check_bit("R7 no pulse while idle", out_valid, 1'b0);
      idle(31);
      check_bit("R7 no pulse while idle", out_valid, 1'b0);
      push(-4, 1'b0);
      idle(17);
      push(20, 1'b1);
      close_check("R7 idle gaps ignored", 25);

      // R4, R6: back-to-back blocks, pulse per block, no carry-over
      push(30, 1'b0); push(12, 1'b1);
      close_check("R6 block A", 42);
      push(-11, 1'b1);
      @(negedge clk);
      in_valid = 1'b1; in_data = 6'd2; in_last = 1'b1;
      checks++;
      if (out_valid !== 1'b1 || $signed(out_result) != -11) begin
         fails++;
         $display("FAIL R6 block B: actual valid=%0b result=%0d expected valid=1 result=-11",
                  out_valid, $signed(out_result));
      end
      close_check("R4 back-to-back block C", 2);
      push(1, 1'b0);
      @(negedge clk);
      in_valid = 1'b0;
      check_bit("R4 no pulse mid-block", out_valid, 1'b0);
      push(1, 1'b1);
      close_check("R6 block after pulses", 2);
      @(negedge clk);
      check_bit("R4 pulse lasts one cycle", out_valid, 1'b0);

      done = 1'b1;
      report();
   end
endmodule